// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block turns a simple request stream into the strobe sequences of an asynchronous DRAM whose row and column addresses share one bus. A request carries a flat word address, a read/write flag and a burst length. The controller puts the row half of the address on the bus and drops the row strobe. It then runs one column access per beat by pulsing the column strobe, and keeps the row strobe low for the whole burst. Later beats only step the column and toggle the column strobe. So they are spaced by the shorter column-cycle minimum, not by the full row-cycle time.

All four device timings (row access, column access, row cycle, column cycle) are given in picoseconds. Each is rounded up to whole cycles of the configured clock period. A refresh timer inside the block raises a pending refresh. The refresh is served only while no burst is open. It opens one row from a wrapping row counter with the column strobe held high, and keeps the row open long enough for a full row access.

Requests use a valid/ready handshake. The requester holds `i_req_valid` and the request fields stable until `o_req_ready` is seen high at a rising clock edge. Write words use a second valid/ready stream, one word per beat. The controller waits with the row open, for as long as it takes, until the word for the next column arrives. Read words come out on `o_rd_valid`/`o_rd_data` with no back-pressure, so the sink must take every word in the cycle it appears.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: `o_req_ready` is high only when the controller is idle, no refresh is pending and at least RC cycles have passed since the last row-strobe fall. On the accepting edge the row strobe falls, and `o_addr` carries the row, which is `i_req_addr[ADDR_W-1:COL_W]`.
- R2: A request makes `i_req_len`+1 column accesses. The first column is `i_req_addr[COL_W-1:0]`, and each later beat adds one modulo 2^COL_W, wrapping inside the same row. The column is on `o_addr` before the column strobe falls.
- R3: The row strobe stays low across every column access of a burst, so there is exactly one row-strobe fall per burst. The column strobe is never low while the row strobe is high.
- R4: Read data is captured on the edge where the column strobe rises. That edge is at least RAC cycles after the row-strobe fall and at least CAC cycles after the column-strobe fall. The captured word is presented for one cycle with `o_rd_valid`=1.
- R5: Two column-strobe falls are never closer than PC cycles. Inside an uninterrupted burst they are exactly PC cycles apart when the column cycle is the binding limit.
- R6: Two row-strobe falls, from bursts or refreshes, are never closer than RC cycles. The row strobe stays high at least one cycle between them.
- R7: A write beat takes its word on an `i_wr_valid`/`o_wr_ready` handshake. The controller drives `o_we_n`=0 and `o_dq_oe`=1 with that word before the column strobe falls, and holds them until it rises. `o_dq_oe` is never 1 while `o_we_n` is 1. While a word is missing, the column strobe stays high and the row stays open.
- R8: `o_oe_n` goes low only for reads, never together with `o_we_n`=0, and `o_dq_oe` stays 0 during reads. With `i_late_oe`=0 it is already low when the column strobe falls. With `i_late_oe`=1 it falls one cycle after the column strobe.
- R9: Every REF_INTERVAL cycles a refresh becomes pending. It is served from idle as a row-strobe-only cycle: the column strobe stays high and the row strobe stays low at least RAC cycles. The refreshed row advances by one each time and wraps from 2^ROW_W-1 to 0, starting from 0.
- R10: A pending refresh never splits a burst. Every row-strobe-low window with column accesses contains all of its burst's beats.
- R11: During and right after reset, all four strobes are high, `o_dq_oe`=0, `o_rd_valid`=0 and `o_req_ready`=1.
- R12: Each cycle count is the ceiling of its picosecond value divided by CLK_PS. With the default 10 ns period, RAC=6, CAC=2, RC=11 and PC=4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| i_clk | input | 1 | Clock |
| i_rst_n | input | 1 | Asynchronous reset, active low |
| i_late_oe | input | 1 | Read output-enable mode, taken at request accept: 0 early, 1 late |
| i_req_valid | input | 1 | Request valid |
| o_req_ready | output | 1 | Request accepted on this edge when high with valid |
| i_req_write | input | 1 | 1 write burst, 0 read burst |
| i_req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| i_req_len | input | LEN_W | Beats minus one |
| i_wr_valid | input | 1 | Write word valid |
| o_wr_ready | output | 1 | Controller takes the write word on this edge |
| i_wr_data | input | DATA_W | Write word |
| o_rd_valid | output | 1 | Read word valid for one cycle |
| o_rd_data | output | DATA_W | Read word |
| o_ras_n | output | 1 | Row strobe, active low |
| o_cas_n | output | 1 | Column strobe, active low |
| o_we_n | output | 1 | Write enable, active low |
| o_oe_n | output | 1 | Output enable, active low |
| o_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| o_dq | output | DATA_W | Data driven to the memory |
| o_dq_oe | output | 1 | 1 while the controller drives `o_dq` |
| i_dq | input | DATA_W | Data returned by the memory |

## Verification
A wrong cycle counter shows up at the strobe pins within one row or column period. A fall comes too early against RC or PC, or a read is captured before RAC or CAC has elapsed. A wrong column or row register shows at the next column-strobe fall as a wrong address. It also shows one beat later as a read word that differs from the word written there. A refresh scheduler that loses its pending flag or row count shows as a missing refresh within one interval, or as a break in the refreshed-row sequence at the following refresh. An FSM that leaves a burst early shows at the row-strobe rise as a window with too few column accesses.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COLADR  = 3'd1,
    ST_CASWAIT = 3'd2,
    ST_CASLO   = 3'd3,
    ST_REF     = 3'd4
  } fpm_state_t;

  // Round a picosecond timing up to whole clock cycles (at least one).
  function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_age_counter.sv
// Counts edges since the last restart, saturating at MAXV; resets saturated.
module fpm_age_counter #(
  parameter int MAXV = 15,
  parameter int W    = 4
) (
  input  logic         i_clk,
  input  logic         i_rst_n,
  input  logic         i_restart,
  output logic [W-1:0] o_age
);

  always_ff @(posedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n) begin
      o_age <= W'(MAXV);
    end else if (i_restart) begin
      o_age <= '0;
    end else if (int'(o_age) < MAXV) begin
      o_age <= o_age + 1'b1;
    end
  end

endmodule

// File: rtl/fpm_refresh_sched.sv
// Interval timer, pending flag and wrapping row counter for refresh.
module fpm_refresh_sched #(
  parameter int INTERVAL = 1560,
  parameter int ROW_W    = 4
) (
  input  logic             i_clk,
  input  logic             i_rst_n,
  input  logic             i_served,
  output logic             o_pending,
  output logic [ROW_W-1:0] o_row
);

  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL + 1) : 1;

  logic [TW-1:0] tmr;
  logic          wrap;

  assign wrap = (tmr == TW'(INTERVAL - 1));

  always_ff @(posedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n) begin
      tmr <= '0;
    end else if (wrap) begin
      tmr <= '0;
    end else begin
      tmr <= tmr + 1'b1;
    end
  end

  always_ff @(posedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n) begin
      o_pending <= 1'b0;
      o_row     <= '0;
    end else begin
      if (wrap) begin
        o_pending <= 1'b1;
      end else if (i_served) begin
        o_pending <= 1'b0;
      end
      if (i_served) begin
        o_row <= o_row + 1'b1;
      end
    end
  end

  AST_PEND_HELD: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    (o_pending && !i_served) |=> o_pending); // R9

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int ROW_W        = 4,
  parameter int COL_W        = 4,
  parameter int DATA_W       = 8,
  parameter int LEN_W        = 3,
  parameter int CLK_PS       = 10000,
  parameter int T_RAC_PS     = 60000,
  parameter int T_CAC_PS     = 15000,
  parameter int T_RC_PS      = 110000,
  parameter int T_PC_PS      = 35000,
  parameter int REF_INTERVAL = 1560,
  localparam int ADDR_W      = ROW_W + COL_W,
  localparam int MUX_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              i_clk,
  input  logic              i_rst_n,
  input  logic              i_late_oe,
  input  logic              i_req_valid,
  output logic              o_req_ready,
  input  logic              i_req_write,
  input  logic [ADDR_W-1:0] i_req_addr,
  input  logic [LEN_W-1:0]  i_req_len,
  input  logic              i_wr_valid,
  output logic              o_wr_ready,
  input  logic [DATA_W-1:0] i_wr_data,
  output logic              o_rd_valid,
  output logic [DATA_W-1:0] o_rd_data,
  output logic              o_ras_n,
  output logic              o_cas_n,
  output logic              o_we_n,
  output logic              o_oe_n,
  output logic [MUX_W-1:0]  o_addr,
  output logic [DATA_W-1:0] o_dq,
  output logic              o_dq_oe,
  input  logic [DATA_W-1:0] i_dq
);
  import fpm_pkg::*;

  localparam int RAC_CYC  = ps_to_cycles(T_RAC_PS, CLK_PS);
  localparam int CAC_CYC  = ps_to_cycles(T_CAC_PS, CLK_PS);
  localparam int RC_CYC   = ps_to_cycles(T_RC_PS, CLK_PS);
  localparam int PC_CYC   = ps_to_cycles(T_PC_PS, CLK_PS);
  // Row-to-column delay and column-strobe low time; together they cover RAC.
  localparam int RCD_CYC  = imax(2, RAC_CYC - CAC_CYC);
  localparam int CASW_CYC = imax(2, CAC_CYC);
  localparam int AGE_MAX  = imax(imax(RC_CYC, PC_CYC), imax(RAC_CYC, imax(RCD_CYC, CASW_CYC)));
  localparam int AGE_W    = $clog2(AGE_MAX + 1);

  fpm_state_t          state;
  logic [ROW_W-1:0]    cur_row;
  logic [COL_W-1:0]    cur_col;
  logic                cur_wr;
  logic                cur_late;
  logic [LEN_W-1:0]    beats_left;

  logic [AGE_W-1:0]    ras_age;
  logic [AGE_W-1:0]    cas_age;
  logic                ref_pend;
  logic [ROW_W-1:0]    ref_row;

  logic                rc_ok;
  logic                ref_go;
  logic                accept;
  logic                cas_ok;
  logic                hold_done;
  logic                ras_fall;
  logic                cas_fall;
  logic                ref_done;

  // ---------------- timing bookkeeping ----------------
  assign rc_ok     = (int'(ras_age) + 1) >= RC_CYC;
  assign cas_ok    = ((int'(ras_age) + 1) >= RCD_CYC) && ((int'(cas_age) + 1) >= PC_CYC);
  assign hold_done = (int'(cas_age) + 1) >= CASW_CYC;
  assign ref_done  = (int'(ras_age) + 1) >= RAC_CYC;

  assign ref_go      = (state == ST_IDLE) && ref_pend && rc_ok;
  assign o_req_ready = (state == ST_IDLE) && !ref_pend && rc_ok;
  assign accept      = o_req_ready && i_req_valid;
  assign o_wr_ready  = (state == ST_COLADR) && cur_wr;

  assign ras_fall = ref_go || accept;
  assign cas_fall = (state == ST_CASWAIT) && cas_ok;

  fpm_age_counter #(.MAXV(AGE_MAX), .W(AGE_W)) u_ras_age (
    .i_clk     (i_clk),
    .i_rst_n   (i_rst_n),
    .i_restart (ras_fall),
    .o_age     (ras_age)
  );

  fpm_age_counter #(.MAXV(AGE_MAX), .W(AGE_W)) u_cas_age (
    .i_clk     (i_clk),
    .i_rst_n   (i_rst_n),
    .i_restart (cas_fall),
    .o_age     (cas_age)
  );

  fpm_refresh_sched #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) u_refresh (
    .i_clk     (i_clk),
    .i_rst_n   (i_rst_n),
    .i_served  (ref_go),
    .o_pending (ref_pend),
    .o_row     (ref_row)
  );

  // ---------------- strobe sequencer ----------------
  always_ff @(posedge i_clk or negedge i_rst_n) begin
    if (!i_rst_n) begin
      state      <= ST_IDLE;
      o_ras_n    <= 1'b1;
      o_cas_n    <= 1'b1;
      o_we_n     <= 1'b1;
      o_oe_n     <= 1'b1;
      o_addr     <= '0;
      o_dq       <= '0;
      o_dq_oe    <= 1'b0;
      o_rd_valid <= 1'b0;
      o_rd_data  <= '0;
      cur_row    <= '0;
      cur_col    <= '0;
      cur_wr     <= 1'b0;
      cur_late   <= 1'b0;
      beats_left <= '0;
    end else begin
      o_rd_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (ref_go) begin
            o_ras_n <= 1'b0;
            o_addr  <= MUX_W'(ref_row);
            state   <= ST_REF;
          end else if (accept) begin
            o_ras_n    <= 1'b0;
            o_addr     <= MUX_W'(i_req_addr[ADDR_W-1:COL_W]);
            cur_row    <= i_req_addr[ADDR_W-1:COL_W];
            cur_col    <= i_req_addr[COL_W-1:0];
            cur_wr     <= i_req_write;
            cur_late   <= i_late_oe;
            beats_left <= i_req_len;
            state      <= ST_COLADR;
          end
        end
        ST_COLADR: begin
          if (!cur_wr || i_wr_valid) begin
            o_addr <= MUX_W'(cur_col);
            if (cur_wr) begin
              o_we_n  <= 1'b0;
              o_dq_oe <= 1'b1;
              o_dq    <= i_wr_data;
            end else if (!cur_late) begin
              o_oe_n <= 1'b0;
            end
            state <= ST_CASWAIT;
          end
        end
        ST_CASWAIT: begin
          if (cas_ok) begin
            o_cas_n <= 1'b0;
            state   <= ST_CASLO;
          end
        end
        ST_CASLO: begin
          if (!cur_wr && cur_late && o_oe_n) begin
            o_oe_n <= 1'b0;
          end
          if (hold_done) begin
            o_cas_n <= 1'b1;
            o_oe_n  <= 1'b1;
            o_we_n  <= 1'b1;
            o_dq_oe <= 1'b0;
            if (!cur_wr) begin
              o_rd_valid <= 1'b1;
              o_rd_data  <= i_dq;
            end
            if (beats_left == '0) begin
              o_ras_n <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              beats_left <= beats_left - 1'b1;
              cur_col    <= cur_col + 1'b1;
              state      <= ST_COLADR;
            end
          end
        end
        ST_REF: begin
          if (ref_done) begin
            o_ras_n <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  AST_RAS_CYCLE_MIN: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    $fell(o_ras_n) |-> (int'($past(ras_age)) + 1) >= RC_CYC); // R6

  AST_CAS_CYCLE_MIN: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    $fell(o_cas_n) |-> (int'($past(cas_age)) + 1) >= PC_CYC); // R5

  AST_CAS_UNDER_RAS: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    !o_cas_n |-> !o_ras_n); // R3

  AST_READ_WINDOW: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    o_rd_valid |-> (int'(ras_age) >= RAC_CYC) && (int'(cas_age) >= CAC_CYC)); // R4

  AST_WDATA_UNDER_WE: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    o_dq_oe |-> !o_we_n); // R7

  AST_OE_WE_EXCL: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    !(!o_oe_n && !o_we_n)); // R8

  AST_REF_RAS_ONLY: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    (state == ST_REF) |-> (o_cas_n && !o_ras_n)); // R9

  AST_READY_ONLY_IDLE: assert property (@(posedge i_clk) disable iff (!i_rst_n)
    o_req_ready |-> o_ras_n); // R1

endmodule

// File: tb/test_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module test_fpm_dram_ctrl;

  localparam int ROW_W = 4, COL_W = 4, DATA_W = 8, LEN_W = 3;
  localparam int CLK_PS = 10000;
  localparam int REF_INT = 300;
  // Expected cycle counts, computed here from the picosecond values.
  localparam int RAC_CYC = (60000 + CLK_PS - 1) / CLK_PS;
  localparam int CAC_CYC = (15000 + CLK_PS - 1) / CLK_PS;
  localparam int RC_CYC  = (110000 + CLK_PS - 1) / CLK_PS;
  localparam int PC_CYC  = (35000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic late_oe = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic o_req_ready, o_wr_ready, o_rd_valid;
  logic [DATA_W-1:0] o_rd_data, o_dq, dq_to_dut;
  logic o_ras_n, o_cas_n, o_we_n, o_oe_n, o_dq_oe;
  logic [3:0] o_addr;

  always #5 clk = ~clk;

  fpm_dram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .LEN_W(LEN_W),
    .CLK_PS(CLK_PS), .REF_INTERVAL(REF_INT)
  ) i_fpm_dram_ctrl (
    .i_clk(clk), .i_rst_n(rst_n), .i_late_oe(late_oe),
    .i_req_valid(req_valid), .o_req_ready(o_req_ready), .i_req_write(req_write),
    .i_req_addr(req_addr), .i_req_len(req_len),
    .i_wr_valid(wr_valid), .o_wr_ready(o_wr_ready), .i_wr_data(wr_data),
    .o_rd_valid(o_rd_valid), .o_rd_data(o_rd_data),
    .o_ras_n(o_ras_n), .o_cas_n(o_cas_n), .o_we_n(o_we_n), .o_oe_n(o_oe_n),
    .o_addr(o_addr), .o_dq(o_dq), .o_dq_oe(o_dq_oe), .i_dq(dq_to_dut)
  );

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- memory model and pin monitor ----------------
  logic [DATA_W-1:0] mem [0:255];
  logic [3:0] m_row = '0, m_col = '0;
  assign dq_to_dut = (!o_oe_n && !o_cas_n && o_we_n) ? mem[{m_row, m_col}] : '0;

  int cyc = 0, ras_fall_t = 0, cas_fall_t = 0;
  bit ras_seen = 0, cas_seen = 0;
  bit p_ras = 1, p_cas = 1, p_we = 1;
  int min_ras_gap = 9999, min_cas_gap = 9999;
  int cas_in_row = 0, last_beats = 0, row_at_fall = 0;
  int col_log [0:15];
  int col_n = 0;
  int oe_low_at_fall = 0;
  int rd_log [0:31];
  int rd_n = 0;
  int ref_rows [0:63];
  int ref_n = 0;
  bit long_phase = 0;
  int v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0, v_r8 = 0, v_r9 = 0, v_r10 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (p_ras && !o_ras_n) begin
        if (ras_seen) begin
          if (cyc - ras_fall_t < min_ras_gap) min_ras_gap = cyc - ras_fall_t;
          if (cyc - ras_fall_t < RC_CYC) v_r6++;
        end
        ras_seen = 1; ras_fall_t = cyc; m_row = o_addr; row_at_fall = int'(o_addr);
        cas_in_row = 0;
      end
      if (p_cas && !o_cas_n) begin
        if (cas_seen && (cyc - cas_fall_t < PC_CYC)) v_r5++;
        if (cas_in_row > 0 && (cyc - cas_fall_t < min_cas_gap)) min_cas_gap = cyc - cas_fall_t;
        cas_seen = 1; cas_fall_t = cyc; m_col = o_addr;
        if (col_n < 16) begin col_log[col_n] = int'(o_addr); col_n++; end
        cas_in_row++;
        if (!o_we_n) begin
          if (!o_dq_oe) v_r7++;
          mem[{m_row, m_col}] = o_dq;
        end else begin
          if (o_dq_oe) v_r8++;
          oe_low_at_fall = int'(!o_oe_n);
        end
      end
      if (!p_cas && o_cas_n && p_we) begin
        if ((cyc - ras_fall_t < RAC_CYC) || (cyc - cas_fall_t < CAC_CYC)) v_r4++;
      end
      if (!p_ras && o_ras_n) begin
        if (cas_in_row == 0) begin
          if (ref_n < 64) begin ref_rows[ref_n] = row_at_fall; ref_n++; end
          if (cyc - ras_fall_t < RAC_CYC) v_r9++;
        end else begin
          last_beats = cas_in_row;
          if (long_phase && cas_in_row != 8) v_r10++;
        end
      end
      if (o_dq_oe && o_we_n) v_r7++;
      if (!o_oe_n && !o_we_n) v_r8++;
      if (!o_cas_n && o_ras_n) v_r3++;
      if (o_rd_valid && rd_n < 32) begin rd_log[rd_n] = int'(o_rd_data); rd_n++; end
      p_ras = o_ras_n; p_cas = o_cas_n; p_we = o_we_n;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic issue(input int row, input int col, input bit wr, input int len, input bit late,
                       input int dbase, input int stall);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = 8'((row << COL_W) | col);
    req_len = LEN_W'(len); late_oe = late;
    while (!o_req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    if (wr) begin
      for (int b = 0; b <= len; b++) begin
        while (!o_wr_ready) @(negedge clk);
        if (b == 0 && stall > 0) begin
          int bad = 0;
          for (int s = 0; s < stall; s++) begin
            if (!o_cas_n || o_ras_n || !o_wr_ready) bad++;
            @(negedge clk);
          end
          chk(bad == 0, "R7", "column strobe held while write word missing", bad, 0);
        end
        wr_valid = 1; wr_data = DATA_W'(dbase + b);
        @(negedge clk);
        wr_valid = 0;
      end
    end
  endtask

  task automatic t_reset;
    chk(o_ras_n && o_cas_n && o_we_n && o_oe_n, "R11", "strobes high in reset",
        int'({o_ras_n, o_cas_n, o_we_n, o_oe_n}), 15);
    chk(!o_dq_oe && !o_rd_valid, "R11", "dq_oe and rd_valid low in reset", int'({o_dq_oe, o_rd_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(o_req_ready, "R11", "ready after reset", int'(o_req_ready), 1);
  endtask

  task automatic t_write_read(input bit late);
    col_n = 0; rd_n = 0;
    issue(3, 14, 1'b1, 3, late, 8'hA0, 0);
    repeat (40) @(negedge clk);
    chk(row_at_fall == 3, "R1", "row on bus at row-strobe fall", row_at_fall, 3);
    chk(last_beats == 4, "R3", "beats in one row window (write)", last_beats, 4);
    chk(col_log[0] == 14 && col_log[1] == 15 && col_log[2] == 0 && col_log[3] == 1, "R2",
        "column sequence wraps in row", col_log[2], 0);
    col_n = 0; rd_n = 0;
    issue(3, 14, 1'b0, 3, late, 0, 0);
    repeat (40) @(negedge clk);
    chk(rd_n == 4, "R4", "read words returned", rd_n, 4);
    for (int i = 0; i < 4; i++)
      chk(rd_log[i] == 8'hA0 + i, "R2", "read word matches written", rd_log[i], 8'hA0 + i);
    chk(oe_low_at_fall == (late ? 0 : 1), "R8", "output enable at column fall vs mode",
        oe_low_at_fall, late ? 0 : 1);
  endtask

  task automatic t_write_stall;
    rd_n = 0;
    issue(9, 2, 1'b1, 1, 1'b0, 8'h5C, 10);
    repeat (40) @(negedge clk);
    issue(9, 2, 1'b0, 1, 1'b0, 0, 0);
    repeat (40) @(negedge clk);
    chk(rd_n == 2 && rd_log[0] == 8'h5C && rd_log[1] == 8'h5D, "R7", "stalled write stored",
        rd_log[0], 8'h5C);
  endtask

  task automatic t_spacing;
    min_ras_gap = 9999; min_cas_gap = 9999;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_len = '0; late_oe = 0; req_addr = 8'h21;
    for (int n = 0; n < 3; n++) begin
      while (!o_req_ready) @(negedge clk);
      @(negedge clk);
      req_addr = req_addr + 8'h10;
    end
    req_valid = 0;
    repeat (30) @(negedge clk);
    chk(min_ras_gap == RC_CYC, "R6", "back-to-back row-strobe spacing (R12)", min_ras_gap, RC_CYC);
    issue(5, 0, 1'b0, 3, 1'b0, 0, 0);
    repeat (40) @(negedge clk);
    chk(min_cas_gap == PC_CYC, "R5", "in-burst column spacing (R12)", min_cas_gap, PC_CYC);
  endtask

  task automatic t_refresh;
    int start, bad, wrapped;
    start = ref_n;
    repeat (17 * REF_INT + 50) @(negedge clk);
    chk(ref_n - start >= 17, "R9", "refreshes during idle", ref_n - start, 17);
    chk(ref_rows[0] == 0, "R9", "first refreshed row", ref_rows[0], 0);
    bad = 0; wrapped = 0;
    for (int i = 1; i < ref_n; i++) begin
      if (ref_rows[i] != ((ref_rows[i-1] + 1) % 16)) bad++;
      if (ref_rows[i-1] == 15 && ref_rows[i] == 0) wrapped = 1;
    end
    chk(bad == 0, "R9", "refresh rows consecutive", bad, 0);
    chk(wrapped == 1, "R9", "refresh row wraps to 0", wrapped, 1);
  endtask

  task automatic t_long_bursts;
    int start;
    start = ref_n;
    long_phase = 1;
    for (int i = 0; i < 24; i++) issue(i % 16, 0, 1'b0, 7, 1'b0, 0, 0);
    repeat (60) @(negedge clk);
    long_phase = 0;
    chk(ref_n - start >= 2, "R10", "refreshes served between bursts", ref_n - start, 2);
    chk(v_r10 == 0, "R10", "burst windows split by refresh", v_r10, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_read(1'b0);
    t_write_read(1'b1);
    t_write_stall();
    t_spacing();
    t_refresh();
    t_long_bursts();
    chk(v_r3 == 0, "R3", "column strobe outside row window", v_r3, 0);
    chk(v_r4 == 0, "R4", "read sampled too early", v_r4, 0);
    chk(v_r5 == 0, "R5", "column spacing violations", v_r5, 0);
    chk(v_r6 == 0, "R6", "row spacing violations", v_r6, 0);
    chk(v_r7 == 0, "R7", "write drive violations", v_r7, 0);
    chk(v_r8 == 0, "R8", "output enable violations", v_r8, 0);
    chk(v_r9 == 0, "R9", "short refresh windows", v_r9, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule